// File: doc/BRIEF.md
# Backend Resource Credit Tracker

This block tells the rename stage how many instructions it may send this cycle. It keeps credits for three backend structures: the reorder buffer, the issue queue and the load/store queue. Each credit is the free count that the stage owning the structure last reported. Instructions that rename has sent but that have not yet been dispatched still hold space, so the block corrects each credit by that in-flight count. From the three corrected credits it picks the tightest one. It then grants the whole group of available instructions, grants only part of it, or blocks.

Each cycle, rename drives the number of instructions it has ready, and a moment later the number it actually renamed. The owning stages drive their free counts with a valid flag. Dispatch drives two counts: how many instructions left for the reorder buffer and issue queue, and how many left for the load/store queue. Physical register availability is checked by other logic. A saturating count of "full" events for each structure is kept for performance analysis.

Top module: `crd_tracker`

## Requirements
- R1: After reset, the stored credits equal the parameters ROB_SIZE, IQ_SIZE and LSQ_SIZE. The in-flight count is zero, rob_empty_o is 1 and all three event counts are zero.
- R2: When a structure's update-valid input is high, its free-count input replaces the stored credit and is used in the same cycle. When the valid input is low, the free-count input has no effect.
- R3: The reorder buffer credit and the issue queue credit are each computed as the effective free count minus (in-flight count minus disp_cnt_i). The result is signed and is not wrapped.
- R4: The load/store queue credit is computed as its effective free count minus (in-flight count minus disp_lsq_cnt_i).
- R5: limiter_o names the structure with the smallest credit, using the codes 0 for the reorder buffer, 1 for the issue queue and 2 for the load/store queue. On a tie the lower code wins.
- R6: When avail_cnt_i is nonzero and the smallest credit is zero or negative, allow_cnt_o is 0 and block_o is 1.
- R7: When avail_cnt_i is nonzero and the smallest credit is positive but less than avail_cnt_i, allow_cnt_o equals that credit and block_o is 1. When the credit is at least avail_cnt_i, allow_cnt_o equals avail_cnt_i and block_o is 0.
- R8: When avail_cnt_i is 0, allow_cnt_o is 0 and block_o is 0. No event is counted in that cycle.
- R9: In every cycle where block_o is 1, the event count of the structure named by limiter_o rises by one at the next clock edge. The count saturates at its maximum value.
- R10: At each clock edge the in-flight count becomes its old value plus renamed_cnt_i minus disp_cnt_i. The result is clamped at zero.
- R11: rob_empty_o loads rob_empty_i on a clock edge where rob_upd_vld_i is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rob_upd_vld_i | input | 1 | Reorder buffer free-count update is valid |
| rob_free_i | input | 5 | Reorder buffer free count |
| rob_empty_i | input | 1 | Reorder buffer is empty, taken together with the update |
| iq_upd_vld_i | input | 1 | Issue queue free-count update is valid |
| iq_free_i | input | 5 | Issue queue free count |
| lsq_upd_vld_i | input | 1 | Load/store queue free-count update is valid |
| lsq_free_i | input | 5 | Load/store queue free count |
| disp_cnt_i | input | 3 | Instructions dispatched this cycle |
| disp_lsq_cnt_i | input | 3 | Instructions dispatched to the load/store queue this cycle |
| renamed_cnt_i | input | 3 | Instructions renamed this cycle |
| avail_cnt_i | input | 3 | Instructions waiting at rename |
| allow_cnt_o | output | 3 | Instructions rename may send |
| block_o | output | 1 | Rename must block |
| limiter_o | output | 2 | Tightest structure: 0 reorder buffer, 1 issue queue, 2 load/store queue |
| rob_empty_o | output | 1 | Last reported reorder buffer empty flag |
| rob_evt_cnt_o | output | 16 | Reorder buffer full events |
| iq_evt_cnt_o | output | 16 | Issue queue full events |
| lsq_evt_cnt_o | output | 16 | Load/store queue full events |

## Verification
allow_cnt_o, block_o and limiter_o are combinational, so they are due in the same cycle as the inputs that produce them. This includes a free-count update, which bypasses its register. The in-flight count, the stored credits, rob_empty_o and the event counts change at the next rising edge. Their effect is therefore due one cycle after the stimulus. The bench drives inputs just after the falling edge and samples the grant outputs 1 ns later. It moves its model of the registered state forward only after the rising edge, so every registered result is compared one cycle after the inputs that caused it.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int unsigned NRES = 3;

  typedef enum logic [1:0] {
    LIM_ROB = 2'd0,
    LIM_IQ  = 2'd1,
    LIM_LSQ = 2'd2
  } lim_e;
endpackage

// File: rtl/crd_slot.sv
module crd_slot #(
  parameter int CW      = 5,
  parameter int IW      = 6,
  parameter int GW      = 3,
  parameter int SW      = 8,
  parameter int RST_VAL = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_vld_i,
  input  logic [CW-1:0]        upd_val_i,
  input  logic [IW-1:0]        inflight_i,
  input  logic [GW-1:0]        drained_i,
  output logic signed [SW-1:0] free_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_eff;
  logic signed [SW-1:0] held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= CW'(RST_VAL);
    else if (upd_vld_i) cnt_q <= upd_val_i;
  end

  // same-cycle bypass of a fresh report
  assign cnt_eff = upd_vld_i ? upd_val_i : cnt_q;
  assign held    = $signed(SW'(inflight_i)) - $signed(SW'(drained_i));
  assign free_o  = $signed(SW'(cnt_eff)) - held;
endmodule

// File: rtl/crd_inflight.sv
module crd_inflight #(
  parameter int IW = 6,
  parameter int GW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] renamed_i,
  input  logic [GW-1:0] drained_i,
  output logic [IW-1:0] inflight_o
);
  localparam logic [IW:0] MAXV = {1'b0, {IW{1'b1}}};

  logic [IW-1:0] cnt_q;
  logic [IW:0]   sum;
  logic [IW:0]   nxt;

  always_comb begin
    sum = {1'b0, cnt_q} + (IW+1)'(renamed_i);
    if ((IW+1)'(drained_i) > sum) nxt = '0;
    else                          nxt = sum - (IW+1)'(drained_i);
    if (nxt > MAXV)               nxt = MAXV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt[IW-1:0];
  end

  assign inflight_o = cnt_q;
endmodule

// File: rtl/crd_limit.sv
module crd_limit
  import crd_pkg::*;
#(
  parameter int GW = 3,
  parameter int SW = 8
) (
  input  logic signed [SW-1:0] free_i [NRES],
  input  logic [GW-1:0]        avail_i,
  output logic [GW-1:0]        allow_o,
  output logic                 block_o,
  output lim_e                 lim_o,
  output logic                 evt_o
);
  logic signed [SW-1:0] min_v;

  always_comb begin
    min_v = free_i[0];
    lim_o = LIM_ROB;
    if (free_i[1] < min_v) begin
      min_v = free_i[1];
      lim_o = LIM_IQ;
    end
    if (free_i[2] < min_v) begin
      min_v = free_i[2];
      lim_o = LIM_LSQ;
    end
  end

  always_comb begin
    allow_o = '0;
    block_o = 1'b0;
    evt_o   = 1'b0;
    if (avail_i == '0) begin
      allow_o = '0;
    end else if (min_v <= 0) begin
      block_o = 1'b1;
      evt_o   = 1'b1;
    end else if (min_v < $signed(SW'(avail_i))) begin
      allow_o = GW'(min_v);
      block_o = 1'b1;
      evt_o   = 1'b1;
    end else begin
      allow_o = avail_i;
    end
  end
endmodule

// File: rtl/crd_evt_ctr.sv
module crd_evt_ctr #(
  parameter int EW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [EW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (inc_i && (~cnt_o != '0))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/crd_tracker.sv
module crd_tracker
  import crd_pkg::*;
#(
  parameter int ROB_SIZE = 16,
  parameter int IQ_SIZE  = 8,
  parameter int LSQ_SIZE = 8,
  parameter int GRP      = 4,
  parameter int EVT_W    = 16,
  localparam int MAXSZ = (ROB_SIZE > IQ_SIZE) ? ((ROB_SIZE > LSQ_SIZE) ? ROB_SIZE : LSQ_SIZE)
                                              : ((IQ_SIZE > LSQ_SIZE) ? IQ_SIZE : LSQ_SIZE),
  localparam int CW = $clog2(MAXSZ + 1),
  localparam int IW = CW + 1,
  localparam int GW = $clog2(GRP + 1),
  localparam int SW = IW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rob_upd_vld_i,
  input  logic [CW-1:0]    rob_free_i,
  input  logic             rob_empty_i,
  input  logic             iq_upd_vld_i,
  input  logic [CW-1:0]    iq_free_i,
  input  logic             lsq_upd_vld_i,
  input  logic [CW-1:0]    lsq_free_i,
  input  logic [GW-1:0]    disp_cnt_i,
  input  logic [GW-1:0]    disp_lsq_cnt_i,
  input  logic [GW-1:0]    renamed_cnt_i,
  input  logic [GW-1:0]    avail_cnt_i,
  output logic [GW-1:0]    allow_cnt_o,
  output logic             block_o,
  output logic [1:0]       limiter_o,
  output logic             rob_empty_o,
  output logic [EVT_W-1:0] rob_evt_cnt_o,
  output logic [EVT_W-1:0] iq_evt_cnt_o,
  output logic [EVT_W-1:0] lsq_evt_cnt_o
);
  function automatic int slot_size(int k);
    case (k)
      0:       return ROB_SIZE;
      1:       return IQ_SIZE;
      default: return LSQ_SIZE;
    endcase
  endfunction

  logic                 upd_vld [NRES];
  logic [CW-1:0]        upd_val [NRES];
  logic [GW-1:0]        drain   [NRES];
  logic signed [SW-1:0] free_v  [NRES];
  logic [EVT_W-1:0]     evt_cnt [NRES];
  logic [IW-1:0]        inflight;
  lim_e                 lim;
  logic                 evt;

  assign upd_vld[0] = rob_upd_vld_i;
  assign upd_vld[1] = iq_upd_vld_i;
  assign upd_vld[2] = lsq_upd_vld_i;
  assign upd_val[0] = rob_free_i;
  assign upd_val[1] = iq_free_i;
  assign upd_val[2] = lsq_free_i;
  assign drain[0]   = disp_cnt_i;
  assign drain[1]   = disp_cnt_i;
  assign drain[2]   = disp_lsq_cnt_i;

  crd_inflight #(.IW(IW), .GW(GW)) u_infl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .renamed_i  (renamed_cnt_i),
    .drained_i  (disp_cnt_i),
    .inflight_o (inflight)
  );

  for (genvar k = 0; k < NRES; k++) begin : g_res
    crd_slot #(.CW(CW), .IW(IW), .GW(GW), .SW(SW), .RST_VAL(slot_size(k))) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .upd_vld_i  (upd_vld[k]),
      .upd_val_i  (upd_val[k]),
      .inflight_i (inflight),
      .drained_i  (drain[k]),
      .free_o     (free_v[k])
    );

    crd_evt_ctr #(.EW(EVT_W)) u_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (evt && (lim == lim_e'(k))),
      .cnt_o  (evt_cnt[k])
    );
  end

  crd_limit #(.GW(GW), .SW(SW)) u_lim (
    .free_i  (free_v),
    .avail_i (avail_cnt_i),
    .allow_o (allow_cnt_o),
    .block_o (block_o),
    .lim_o   (lim),
    .evt_o   (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rob_empty_o <= 1'b1;
    else if (rob_upd_vld_i) rob_empty_o <= rob_empty_i;
  end

  assign limiter_o     = lim;
  assign rob_evt_cnt_o = evt_cnt[0];
  assign iq_evt_cnt_o  = evt_cnt[1];
  assign lsq_evt_cnt_o = evt_cnt[2];
endmodule

// File: rtl/crd_tracker_chk.sv
module crd_tracker_chk #(
  parameter int GW = 3,
  parameter int EW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rob_upd_vld_i,
  input logic [GW-1:0] avail_cnt_i,
  input logic [GW-1:0] allow_cnt_o,
  input logic          block_o,
  input logic [1:0]    limiter_o,
  input logic          rob_empty_o,
  input logic [EW-1:0] rob_evt_cnt_o,
  input logic [EW-1:0] iq_evt_cnt_o
);
  // R7
  no_over_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_cnt_o <= avail_cnt_i);

  // R7
  full_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !block_o |-> (allow_cnt_o == avail_cnt_i));

  // R8
  idle_no_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_cnt_i == '0) |-> !block_o);

  // R5
  limiter_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limiter_o != 2'd3);

  // R9
  rob_evt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rob_evt_cnt_o != $past(rob_evt_cnt_o)) |->
      (rob_evt_cnt_o == EW'($past(rob_evt_cnt_o) + 1'b1)) && $past(block_o) && ($past(limiter_o) == 2'd0));

  // R9
  iq_evt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iq_evt_cnt_o != $past(iq_evt_cnt_o)) |->
      (iq_evt_cnt_o == EW'($past(iq_evt_cnt_o) + 1'b1)) && $past(block_o) && ($past(limiter_o) == 2'd1));

  // R11
  rob_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rob_upd_vld_i) |-> $stable(rob_empty_o));
endmodule

bind crd_tracker crd_tracker_chk #(.GW(GW), .EW(EVT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rob_upd_vld_i (rob_upd_vld_i),
  .avail_cnt_i   (avail_cnt_i),
  .allow_cnt_o   (allow_cnt_o),
  .block_o       (block_o),
  .limiter_o     (limiter_o),
  .rob_empty_o   (rob_empty_o),
  .rob_evt_cnt_o (rob_evt_cnt_o),
  .iq_evt_cnt_o  (iq_evt_cnt_o)
);

// File: tb/sim_crd_tracker.sv
`timescale 1ns/1ps
module sim_crd_tracker;
  localparam int ROBS = 16, IQS = 8, LSQS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rob_v = 0, rob_e = 1, iq_v = 0, lsq_v = 0;
  logic [4:0] rob_f = 0, iq_f = 0, lsq_f = 0;
  logic [2:0] dc = 0, dl = 0, rn = 0, av = 0;
  logic [2:0] allow;
  logic       blk, empty;
  logic [1:0] lim;
  logic [15:0] ec_rob, ec_iq, ec_lsq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_rob = ROBS, m_iq = IQS, m_lsq = LSQS, m_infl = 0, m_empty = 1;
  int m_ev [3] = '{0, 0, 0};
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  crd_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rob_upd_vld_i(rob_v), .rob_free_i(rob_f), .rob_empty_i(rob_e),
    .iq_upd_vld_i(iq_v), .iq_free_i(iq_f),
    .lsq_upd_vld_i(lsq_v), .lsq_free_i(lsq_f),
    .disp_cnt_i(dc), .disp_lsq_cnt_i(dl), .renamed_cnt_i(rn), .avail_cnt_i(av),
    .allow_cnt_o(allow), .block_o(blk), .limiter_o(lim), .rob_empty_o(empty),
    .rob_evt_cnt_o(ec_rob), .iq_evt_cnt_o(ec_iq), .lsq_evt_cnt_o(ec_lsq)
  );

  task automatic chk(string ph, string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s %s act=%0d exp=%0d", ph, req, what, act, exp);
    end
  endtask

  task automatic step(string ph, bit rv, int rf, bit re, bit iv, int ivl, bit lv, int lf,
                      int d, int dlq, int r, int a);
    int er, ei, el, f0, f1, f2, mn, ml, ea, eb, evt;
    string rq;
    @(negedge clk);
    rob_v = rv; rob_f = 5'(rf); rob_e = re; iq_v = iv; iq_f = 5'(ivl);
    lsq_v = lv; lsq_f = 5'(lf); dc = 3'(d); dl = 3'(dlq); rn = 3'(r); av = 3'(a);
    #1;
    // registered state from earlier cycles
    chk(ph, "R9", "rob_evt", int'(ec_rob), m_ev[0]);
    chk(ph, "R9", "iq_evt", int'(ec_iq), m_ev[1]);
    chk(ph, "R9", "lsq_evt", int'(ec_lsq), m_ev[2]);
    chk(ph, "R11", "rob_empty", int'(empty), m_empty);
    er = rv ? rf : m_rob;
    ei = iv ? ivl : m_iq;
    el = lv ? lf : m_lsq;
    f0 = er - (m_infl - d);
    f1 = ei - (m_infl - d);
    f2 = el - (m_infl - dlq);
    mn = f0; ml = 0;
    if (f1 < mn) begin mn = f1; ml = 1; end
    if (f2 < mn) begin mn = f2; ml = 2; end
    evt = 0;
    if (a == 0)      begin ea = 0;  eb = 0; rq = "R8"; end
    else if (mn <= 0) begin ea = 0;  eb = 1; evt = 1; rq = "R6"; end
    else if (mn < a)  begin ea = mn; eb = 1; evt = 1; rq = "R7"; end
    else              begin ea = a;  eb = 0; rq = "R3"; end
    chk(ph, rq, "allow", int'(allow), ea);
    chk(ph, rq, "block", int'(blk), eb);
    chk(ph, "R5", "limiter", int'(lim), ml);
    @(posedge clk);
    m_rob = er; m_iq = ei; m_lsq = el;
    if (rv) m_empty = re;
    m_infl = m_infl + r - d;
    if (m_infl < 0) m_infl = 0;
    if (m_infl > 63) m_infl = 63;
    if (evt && m_ev[ml] < 65535) m_ev[ml]++;
  endtask

  function automatic logic [15:0] nxt_lfsr(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset credits, empty flag, zero in-flight and counters
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2: sweep bypassed free counts against every group size
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < 6; i++)
        for (int l = 0; l < 6; l++)
          for (int a = 0; a < 5; a++)
            step("R2", 1, r, 1, 1, i, 1, l, 0, 0, 0, a);

    // R2: inputs with valid low are ignored
    step("R2", 1, 9, 1, 1, 9, 1, 9, 0, 0, 0, 4);
    step("R2", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4);
    step("R2", 0, 1, 1, 0, 2, 0, 3, 0, 0, 0, 4);

    // R4: load/store credit uses its own dispatch count
    step("R4", 1, 10, 1, 1, 10, 1, 10, 0, 0, 3, 4);
    step("R4", 0, 0, 1, 0, 0, 0, 0, 0, 0, 3, 4);
    step("R4", 0, 0, 1, 0, 0, 0, 0, 3, 0, 0, 4);
    step("R4", 0, 0, 1, 0, 0, 0, 0, 1, 3, 0, 4);

    // R11: empty flag capture and hold
    step("R11", 1, 12, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R11", 0, 12, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R11", 1, 12, 1, 0, 0, 0, 0, 0, 0, 0, 1);

    // R10: in-flight clamps at zero when dispatch exceeds it
    step("R10", 1, 8, 1, 1, 8, 1, 8, 0, 0, 0, 4);
    step("R10", 0, 0, 1, 0, 0, 0, 0, 4, 4, 0, 4);
    step("R10", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4);

    // R10: mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a, b;
      lfsr = nxt_lfsr(lfsr); a = lfsr;
      lfsr = nxt_lfsr(lfsr); b = lfsr;
      step("R10", a[1:0] == 0, int'(a[5:2]), a[6], a[8:7] == 0, int'(a[12:9]),
           b[1:0] == 0, int'(b[5:2]),
           int'(b[7:6]) + int'(b[8]), int'(b[10:9]) + int'(b[11]),
           (m_infl < 20) ? int'(a[14:13]) : 0, int'(b[14:12]) % 5);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule